// File: doc/BRIEF.md
# DMA Fixed-Port Transfer Channel

This block is a single DMA channel that shuttles data between a moving memory location and one fixed peripheral location. Every accepted request strobe causes exactly one unit (a byte or a 16-bit word) to be read from the source and then written to the destination over a simple ready-handshaked bus master port. The memory side address walks up or down by the unit size after each unit. The peripheral side address stays constant. Its low eight bits come from a configuration field, and every bit above them is one.

Which side is the source is not a configuration bit. It is decided per request from the code of the event that raised it. The receive-data-full event of serial channel 0 pulls data from the peripheral into memory. Any other event pushes data from memory to the peripheral. A 16-bit count sets how many units are moved. When the count is exhausted the channel turns itself off, flags completion and optionally raises an interrupt.

Top module: `dma_fixport_chan`

## Requirements
- R1: A `cfg_load` pulse while no transfer is in progress loads the memory address, peripheral offset, count, unit size, step direction and interrupt enable. It sets `active` and clears `done`, `irq` and `addr_err`. A `cfg_load` pulse during a transfer has no effect.
- R2: Each accepted request produces one read cycle (`bus_write`=0) followed by one write cycle (`bus_write`=1). Each cycle holds `bus_valid`, `bus_addr`, `bus_write` and `bus_wdata` steady until `bus_ready` is seen.
- R3: The peripheral-side address on the bus is the 8-bit offset with bits 23:8 all ones. It never changes across transfers.
- R4: A request whose `req_src` equals 3'd4 (serial channel 0 receive full) reads the peripheral address and writes the memory address. Every other code reads the memory address and writes the peripheral address.
- R5: After each completed write, `mem_addr` steps by 1 in byte mode or 2 in word mode. It steps up when the step-direction bit is 0 and down when it is 1, wrapping modulo 2^24.
- R6: `count` decreases by one per completed transfer. On the transfer that brings it to zero, `active` drops and `done` rises.
- R7: `irq` rises together with `done` only if the interrupt enable bit was loaded as 1. It stays until the next load.
- R8: Requests are ignored while `active` is 0 (before any load or after completion) and while a transfer is in progress. No bus cycle starts and no register moves.
- R9: In word mode, a request made while the memory address or the peripheral offset is odd starts no bus cycle. It sets `addr_err` and leaves `mem_addr`, `count` and `active` unchanged.
- R10: The write data equals the data just read: all 16 bits in word mode, the low 8 bits with zeroed upper byte in byte mode. `bus_word` shows the unit size on both cycles.
- R11: After reset, `bus_valid`, `busy`, `active`, `done`, `irq` and `addr_err` are 0, and `mem_addr` and `count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Load configuration and arm channel |
| cfg_mem_addr | input | 24 | Initial memory-side address |
| cfg_io_off | input | 8 | Low byte of the fixed peripheral address |
| cfg_count | input | 16 | Number of units to move |
| cfg_word | input | 1 | 1 = word units, 0 = byte units |
| cfg_dec | input | 1 | 1 = memory address steps down |
| cfg_irq_en | input | 1 | Enable interrupt at completion |
| req | input | 1 | Transfer request strobe |
| req_src | input | 3 | Code of the requesting event |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_write | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_word | output | 1 | Unit size of the cycle |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Completes the current bus cycle |
| mem_addr | output | 24 | Current memory-side address |
| count | output | 16 | Remaining unit count |
| active | output | 1 | Channel armed |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Count reached zero |
| irq | output | 1 | Completion interrupt |
| addr_err | output | 1 | Misaligned word request seen |

## Verification
The bench sweeps every request code against both unit sizes and both step directions. A design that derived direction from the wrong code, or let a non-receive code pull from the peripheral, would show swapped read and write addresses. Wait states of zero to two cycles on each bus phase catch a sequencer that samples data or updates the address before `ready`. A decrement from a low address and an increment from 0xFFFFFF check the step arithmetic and its wraparound. Misaligned word requests on either side, and requests or loads issued mid-transfer or after completion, must leave `mem_addr` and `count` untouched. A design that ignored any of these would corrupt state or start a stray bus cycle.

// File: rtl/dma_fix_pkg.sv
// Package: shared types of the fixed-port DMA channel.
// Assumes: nothing beyond IEEE 1800-2017.
package dma_fix_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } dma_state_e;
endpackage

// File: rtl/dma_fix_addr.sv
// Module: address generator of the fixed-port DMA channel.
// Holds the memory-side address and the peripheral offset, forms the
// fixed peripheral address, picks source/destination and flags misalignment.
// Assumes: step_en and load are never high in the same cycle as each other
// with conflicting intent; load wins.
module dma_fix_addr #(
    parameter int AW  = 24,
    parameter int IOW = 8,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [AW-1:0]  load_mem,
    input  logic [IOW-1:0] load_io,
    input  logic           word_mode,
    input  logic           dec_mode,
    input  logic           step_en,
    input  logic           to_mem,
    input  logic           write_phase,
    output logic [AW-1:0]  mem_addr,
    output logic [AW-1:0]  bus_addr,
    output logic           misaligned
);
    localparam int HIW = AW - IOW;
    localparam logic [AW-1:0] BYTE_STEP = AW'(1);
    localparam logic [AW-1:0] WORD_STEP = AW'(DW / 8);

    logic [AW-1:0]  mem_q;
    logic [IOW-1:0] io_q;
    logic [AW-1:0]  io_full;
    logic [AW-1:0]  step;
    logic [AW-1:0]  src_addr;
    logic [AW-1:0]  dst_addr;

    // Hold and advance the memory address; hold the peripheral offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
            io_q  <= '0;
        end else if (load) begin
            mem_q <= load_mem;
            io_q  <= load_io;
        end else if (step_en) begin
            mem_q <= dec_mode ? (mem_q - step) : (mem_q + step);
        end
    end

    // Form the fixed address, pick source and destination, check alignment.
    always_comb begin
        step       = word_mode ? WORD_STEP : BYTE_STEP;
        io_full    = {{HIW{1'b1}}, io_q};
        src_addr   = to_mem ? io_full : mem_q;
        dst_addr   = to_mem ? mem_q : io_full;
        bus_addr   = write_phase ? dst_addr : src_addr;
        misaligned = word_mode && (mem_q[0] || io_q[0]);
    end

    assign mem_addr = mem_q;
endmodule

// File: rtl/dma_fix_count.sv
// Module: transfer counter of the fixed-port DMA channel.
// Loads the unit count and counts down once per completed transfer.
// Assumes: dec_en only pulses when a transfer finishes.
module dma_fix_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec_en,
    output logic [CW-1:0] count,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // Load or decrement the remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec_en) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    assign count = cnt_q;
    assign last  = (cnt_q == CW'(1));
endmodule

// File: rtl/dma_fix_seq.sv
// Module: sequencer of the fixed-port DMA channel.
// Accepts requests, picks direction from the request code, runs the
// read-then-write bus sequence and keeps the mode and status flags.
// Assumes: bus_ready is only meaningful while bus_valid is high.
module dma_fix_seq
    import dma_fix_pkg::*;
#(
    parameter int                DW          = 16,
    parameter int                SRCW        = 3,
    parameter logic [SRCW-1:0]   RXFULL_CODE = SRCW'(4)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_load,
    input  logic            cfg_word,
    input  logic            cfg_dec,
    input  logic            cfg_irq_en,
    input  logic            req,
    input  logic [SRCW-1:0] req_src,
    input  logic            misaligned,
    input  logic            last_xfer,
    input  logic            bus_ready,
    input  logic [DW-1:0]   bus_rdata,
    output logic            load_ok,
    output logic            step_en,
    output logic            to_mem,
    output logic            word_mode,
    output logic            dec_mode,
    output logic            bus_valid,
    output logic            bus_write,
    output logic [DW-1:0]   bus_wdata,
    output logic            busy,
    output logic            active,
    output logic            done,
    output logic            irq,
    output logic            addr_err
);
    dma_state_e    state_q;
    logic          accept;
    logic          go;
    logic          abort;
    logic          irq_en_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rd_unit;

    // Decode handshakes and request acceptance.
    always_comb begin
        load_ok   = cfg_load && (state_q == ST_IDLE);
        accept    = req && active && (state_q == ST_IDLE) && !cfg_load;
        go        = accept && !misaligned;
        abort     = accept && misaligned;
        step_en   = (state_q == ST_WRITE) && bus_ready;
        bus_valid = (state_q != ST_IDLE);
        bus_write = (state_q == ST_WRITE);
        busy      = (state_q != ST_IDLE);
        rd_unit   = word_mode ? bus_rdata : {{(DW-8){1'b0}}, bus_rdata[7:0]};
    end

    // Step the read-then-write state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (go)        state_q <= ST_READ;
                ST_READ:  if (bus_ready) state_q <= ST_WRITE;
                ST_WRITE: if (bus_ready) state_q <= ST_IDLE;
                default:                 state_q <= ST_IDLE;
            endcase
        end
    end

    // Latch the direction at acceptance and the data at read completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_mem <= 1'b0;
            data_q <= '0;
        end else begin
            if (go) to_mem <= (req_src == RXFULL_CODE);
            if ((state_q == ST_READ) && bus_ready) data_q <= rd_unit;
        end
    end

    // Keep mode bits and status flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_mode <= 1'b0;
            dec_mode  <= 1'b0;
            irq_en_q  <= 1'b0;
            active    <= 1'b0;
            done      <= 1'b0;
            irq       <= 1'b0;
            addr_err  <= 1'b0;
        end else if (load_ok) begin
            word_mode <= cfg_word;
            dec_mode  <= cfg_dec;
            irq_en_q  <= cfg_irq_en;
            active    <= 1'b1;
            done      <= 1'b0;
            irq       <= 1'b0;
            addr_err  <= 1'b0;
        end else begin
            if (abort) addr_err <= 1'b1;
            if (step_en && last_xfer) begin
                active <= 1'b0;
                done   <= 1'b1;
                irq    <= irq_en_q;
            end
        end
    end

    assign bus_wdata = data_q;
endmodule

// File: rtl/dma_fixport_chan.sv
// Module: top of the fixed-port DMA channel.
// Ties the address generator, counter and sequencer together.
// Assumes: the bus slave raises bus_ready for one cycle per bus cycle.
module dma_fixport_chan #(
    parameter int              AW          = 24,
    parameter int              IOW         = 8,
    parameter int              CW          = 16,
    parameter int              DW          = 16,
    parameter int              SRCW        = 3,
    parameter logic [SRCW-1:0] RXFULL_CODE = SRCW'(4)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_load,
    input  logic [AW-1:0]   cfg_mem_addr,
    input  logic [IOW-1:0]  cfg_io_off,
    input  logic [CW-1:0]   cfg_count,
    input  logic            cfg_word,
    input  logic            cfg_dec,
    input  logic            cfg_irq_en,
    input  logic            req,
    input  logic [SRCW-1:0] req_src,
    output logic            bus_valid,
    output logic            bus_write,
    output logic            bus_word,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ready,
    output logic [AW-1:0]   mem_addr,
    output logic [CW-1:0]   count,
    output logic            active,
    output logic            busy,
    output logic            done,
    output logic            irq,
    output logic            addr_err
);
    logic load_ok;
    logic step_en;
    logic to_mem;
    logic word_mode;
    logic dec_mode;
    logic misaligned;
    logic last_xfer;

    dma_fix_seq #(.DW(DW), .SRCW(SRCW), .RXFULL_CODE(RXFULL_CODE)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_load(cfg_load), .cfg_word(cfg_word), .cfg_dec(cfg_dec),
        .cfg_irq_en(cfg_irq_en), .req(req), .req_src(req_src),
        .misaligned(misaligned), .last_xfer(last_xfer),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .load_ok(load_ok), .step_en(step_en), .to_mem(to_mem),
        .word_mode(word_mode), .dec_mode(dec_mode),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_wdata(bus_wdata),
        .busy(busy), .active(active), .done(done), .irq(irq),
        .addr_err(addr_err)
    );

    dma_fix_addr #(.AW(AW), .IOW(IOW), .DW(DW)) u_addr (
        .clk(clk), .rst_n(rst_n), .load(load_ok),
        .load_mem(cfg_mem_addr), .load_io(cfg_io_off),
        .word_mode(word_mode), .dec_mode(dec_mode), .step_en(step_en),
        .to_mem(to_mem), .write_phase(bus_write),
        .mem_addr(mem_addr), .bus_addr(bus_addr), .misaligned(misaligned)
    );

    dma_fix_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load_ok), .load_val(cfg_count),
        .dec_en(step_en), .count(count), .last(last_xfer)
    );

    assign bus_word = word_mode;
endmodule

// File: rtl/dma_fixport_chan_chk.sv
// Module: property checker for the fixed-port DMA channel, bound to the top.
// Assumes: observes top-level ports only.
module dma_fixport_chan_chk #(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_load,
    input logic          bus_valid,
    input logic          bus_write,
    input logic          bus_ready,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [AW-1:0] mem_addr,
    input logic [CW-1:0] count,
    input logic          active,
    input logic          done,
    input logic          irq,
    input logic          addr_err
);
    p_bus_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
            && $stable(bus_write) && $stable(bus_wdata));

    p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_write && bus_ready |=> bus_valid && bus_write);

    p_mem_moves_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) && !$past(cfg_load) |->
            $past(bus_valid && bus_write && bus_ready));

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(count) && !$past(cfg_load) |->
            count == CW'($past(count) - 1'b1));

    p_done_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !active);

    p_irq_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    p_err_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_err) |-> !bus_valid);
endmodule

bind dma_fixport_chan dma_fixport_chan_chk #(.AW(AW), .CW(CW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mem_addr(mem_addr),
    .count(count), .active(active), .done(done), .irq(irq),
    .addr_err(addr_err)
);

// File: tb/dma_fixport_chan_bench.sv
// Bench: sweeps request codes, unit sizes, step directions and wait states.
module dma_fixport_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [23:0] cfg_mem_addr = '0;
    logic [7:0]  cfg_io_off = '0;
    logic [15:0] cfg_count = '0;
    logic        cfg_word = 1'b0;
    logic        cfg_dec = 1'b0;
    logic        cfg_irq_en = 1'b0;
    logic        req = 1'b0;
    logic [2:0]  req_src = '0;
    logic        bus_valid, bus_write, bus_word;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ready = 1'b0;
    logic [23:0] mem_addr;
    logic [15:0] count;
    logic        active, busy, done, irq, addr_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Model state.
    logic [23:0] m_mar;
    logic [15:0] m_cnt;
    logic [7:0]  m_io;
    logic        m_word, m_dec, m_irqen;

    always #5 clk = ~clk;

    dma_fixport_chan u_dma_fixport_chan (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_mem_addr(cfg_mem_addr), .cfg_io_off(cfg_io_off),
        .cfg_count(cfg_count), .cfg_word(cfg_word), .cfg_dec(cfg_dec),
        .cfg_irq_en(cfg_irq_en), .req(req), .req_src(req_src),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .mem_addr(mem_addr), .count(count),
        .active(active), .busy(busy), .done(done), .irq(irq),
        .addr_err(addr_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_load(input logic [23:0] ma, input logic [7:0] io,
                           input logic [15:0] cnt, input logic w, input logic d,
                           input logic ie);
        @(negedge clk);
        cfg_mem_addr = ma; cfg_io_off = io; cfg_count = cnt;
        cfg_word = w; cfg_dec = d; cfg_irq_en = ie; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        m_mar = ma; m_io = io; m_cnt = cnt; m_word = w; m_dec = d; m_irqen = ie;
    endtask

    task automatic pulse_req(input logic [2:0] src);
        req = 1'b1; req_src = src;
        @(negedge clk);
        req = 1'b0;
    endtask

    // Serve one bus cycle: wait for it, check it, then complete it.
    task automatic serve(input logic exp_wr, input logic [23:0] exp_addr,
                         input int waits, input logic [15:0] rd,
                         input bit chk_wd, input logic [15:0] exp_wd);
        int guard = 0;
        while (!bus_valid && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        chk("R2 bus cycle started", {31'd0, bus_valid}, 32'd1);
        chk("R2 cycle kind", {31'd0, bus_write}, {31'd0, exp_wr});
        chk("R3/R4 cycle address", {8'd0, bus_addr}, {8'd0, exp_addr});
        chk("R10 unit size", {31'd0, bus_word}, {31'd0, m_word});
        if (chk_wd) chk("R10 write data", {16'd0, bus_wdata}, {16'd0, exp_wd});
        for (int k = 0; k < waits; k++) @(negedge clk);
        chk("R2 held through wait", {8'd0, bus_addr}, {8'd0, exp_addr});
        bus_ready = 1'b1; bus_rdata = rd;
        @(negedge clk);
        bus_ready = 1'b0;
    endtask

    // One full transfer against the model, then register checks.
    task automatic one_xfer(input logic [2:0] src, input int waits, input logic [15:0] rd);
        logic        to_mem_e;
        logic [23:0] io_full;
        logic [15:0] wd;
        to_mem_e = (src == 3'd4);
        io_full  = {16'hFFFF, m_io};
        wd       = m_word ? rd : {8'h00, rd[7:0]};
        pulse_req(src);
        serve(1'b0, to_mem_e ? io_full : m_mar, waits, rd, 1'b0, 16'h0);
        serve(1'b1, to_mem_e ? m_mar : io_full, (waits + 1) % 3, 16'h0, 1'b1, wd);
        m_mar = m_dec ? m_mar - (m_word ? 24'd2 : 24'd1) : m_mar + (m_word ? 24'd2 : 24'd1);
        m_cnt = m_cnt - 16'd1;
        chk("R5 memory address step", {8'd0, mem_addr}, {8'd0, m_mar});
        chk("R6 count step", {16'd0, count}, {16'd0, m_cnt});
        chk("R6 active", {31'd0, active}, {31'd0, m_cnt != 0});
        chk("R6 done", {31'd0, done}, {31'd0, m_cnt == 0});
        chk("R7 irq", {31'd0, irq}, {31'd0, (m_cnt == 0) && m_irqen});
    endtask

    // Issue a request that must be ignored and check nothing moved.
    task automatic ignored_req(input string tag);
        logic seen = 1'b0;
        pulse_req(3'd1);
        for (int k = 0; k < 4; k++) begin
            if (bus_valid) seen = 1'b1;
            @(negedge clk);
        end
        chk({tag, " no bus cycle"}, {31'd0, seen}, 32'd0);
        chk({tag, " address held"}, {8'd0, mem_addr}, {8'd0, m_mar});
        chk({tag, " count held"}, {16'd0, count}, {16'd0, m_cnt});
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        m_mar = '0; m_cnt = '0; m_io = '0; m_word = 0; m_dec = 0; m_irqen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 bus_valid", {31'd0, bus_valid}, 32'd0);
        chk("R11 flags", {27'd0, busy, active, done, irq, addr_err}, 32'd0);
        chk("R11 mem_addr", {8'd0, mem_addr}, 32'd0);
        chk("R11 count", {16'd0, count}, 32'd0);
        ignored_req("R8 before load");

        // Main sweep: unit size x direction x request code.
        for (int w = 0; w < 2; w++) begin
            for (int d = 0; d < 2; d++) begin
                for (int s = 0; s < 8; s++) begin
                    logic [23:0] base;
                    base = (w != 0) ? 24'h12_3456 : 24'h12_3457;
                    if (d != 0 && s == 2) base = (w != 0) ? 24'h00_0002 : 24'h00_0001;
                    do_load(base, 8'h40 + 8'(s * 2), 16'd3, w[0], d[0], s[0]);
                    chk("R1 active after load", {31'd0, active}, 32'd1);
                    chk("R1 loaded address", {8'd0, mem_addr}, {8'd0, base});
                    for (int i = 0; i < 3; i++)
                        one_xfer(3'(s), (i + s) % 3, 16'hA500 ^ 16'(s * 16 + i));
                    ignored_req("R8 after done");
                end
            end
        end

        // R5 wraparound going up from the top address.
        do_load(24'hFF_FFFF, 8'h10, 16'd1, 1'b0, 1'b0, 1'b1);
        one_xfer(3'd2, 0, 16'h00C3);
        chk("R5 wrap to zero", {8'd0, mem_addr}, 32'd0);

        // R1/R8 load and request during a transfer are ignored.
        do_load(24'h00_2000, 8'h20, 16'd2, 1'b1, 1'b0, 1'b0);
        req = 1'b1; req_src = 3'd1;
        @(negedge clk);
        req = 1'b0;
        cfg_mem_addr = 24'h55_5550; cfg_count = 16'h0077; cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        serve(1'b0, 24'h00_2000, 1, 16'h1234, 1'b0, 16'h0);
        serve(1'b1, 24'hFF_FF20, 0, 16'h0, 1'b1, 16'h1234);
        m_mar = 24'h00_2002; m_cnt = 16'd1;
        chk("R1 load ignored mid-transfer count", {16'd0, count}, 32'd1);
        chk("R1 load ignored mid-transfer address", {8'd0, mem_addr}, {8'd0, m_mar});
        chk("R8 busy request ignored", {31'd0, bus_valid}, 32'd0);

        // R9 misaligned memory side in word mode.
        do_load(24'h00_3001, 8'h30, 16'd4, 1'b1, 1'b0, 1'b0);
        pulse_req(3'd0);
        chk("R9 addr_err on odd memory", {31'd0, addr_err}, 32'd1);
        chk("R9 still active", {31'd0, active}, 32'd1);
        ignored_req("R9 odd memory");
        // R9 misaligned peripheral side in word mode.
        do_load(24'h00_3000, 8'h31, 16'd4, 1'b1, 1'b1, 1'b0);
        chk("R1 addr_err cleared by load", {31'd0, addr_err}, 32'd0);
        pulse_req(3'd4);
        chk("R9 addr_err on odd offset", {31'd0, addr_err}, 32'd1);
        ignored_req("R9 odd offset");
        // Same odd offset is fine in byte mode.
        do_load(24'h00_3001, 8'h31, 16'd1, 1'b0, 1'b1, 1'b1);
        one_xfer(3'd4, 1, 16'hBEEF);
        chk("R9 byte mode no error", {31'd0, addr_err}, 32'd0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule